// File: doc/BRIEF.md
# SMM Resume Action Selector

This block sits inside a processor's system-management controller and decides where execution continues when the handler issues its resume instruction. When the core enters system-management mode, the block records two facts. The first is whether the core was sitting in the halt state. The second is whether the management interrupt arrived on an I/O instruction boundary. It also places fresh values in two save-area slots: a halt-restart word and an I/O-restart word.

While in the mode, handler software reads and writes either slot through a small register port. When the resume request arrives, the block combines the halt status captured at entry with the current slot contents. For one cycle it presents a one-hot resume action with a valid strobe. Combinations that have no defined meaning raise an error flag, and the block then falls back to the safe choice of continuing at the next instruction.

Top module: `smm_resume_ctl`

## Requirements
- R1: An entry pulse accepted outside the mode sets `in_smm_o`, loads the halt-restart word with the halted input in bit 0 and zeros in every other bit, clears the I/O-restart word to 0x0000, and latches the halted and I/O-boundary inputs internally.
- R2: The register port selects the I/O-restart word with `reg_sel_i`=0 and the halt-restart word with `reg_sel_i`=1. A write inside the mode updates the selected word on the next clock edge. `reg_rdata_o` shows the selected word combinationally.
- R3: Writes outside the mode leave both words unchanged. An entry pulse while already in the mode is ignored and does not reload either word or the latched entry status.
- R4: A resume request inside the mode raises `act_valid_o` in the following cycle for exactly one cycle and clears `in_smm_o`. A resume request outside the mode produces no strobe. A write in the same cycle as an accepted resume request is dropped.
- R5: `act_o` is one-hot while valid and all-zero otherwise: bit 0 continues at the next instruction, bit 1 continues after the HALT, bit 2 re-enters the halt state, and bit 3 re-executes the trapped I/O instruction. `act_err_o` is 0 whenever the strobe is low.
- R6: Halted 0 at entry and halt bit 0 at resume, with the I/O word 0x0000, selects next instruction without error.
- R7: Halted 1 at entry and halt bit 0 at resume, with the I/O word 0x0000, selects continue-after-HALT.
- R8: Halted 1 at entry and halt bit 1 at resume, with the I/O word 0x0000, selects re-enter halt.
- R9: An I/O word of 0x00FF with the boundary flag latched as set selects I/O re-execute, whatever the halt decision would have been.
- R10: Halted 0 at entry with halt bit 1 at resume, a nonzero I/O word without a latched boundary, or an I/O word other than 0x0000 and 0x00FF each set `act_err_o` and select next instruction.
- R11: Bits 15..1 of the halt-restart word do not affect the action, and only the halted value latched at entry counts as the entry status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_i | input | 1 | Mode-entry pulse |
| halted_i | input | 1 | Core is in halt state at entry |
| io_boundary_i | input | 1 | Interrupt arrived on an I/O instruction boundary |
| rsm_req_i | input | 1 | Resume request pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Slot select: 0 I/O-restart word, 1 halt-restart word |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Selected slot contents |
| in_smm_o | output | 1 | Block is inside the mode |
| act_valid_o | output | 1 | Resume action strobe |
| act_o | output | 4 | One-hot resume action |
| act_err_o | output | 1 | Undefined combination detected |

## Verification
The bench builds the block with its default 16-bit slot width and the re-execute code 0x00FF, so every magic-value comparison uses the exact code that handler software writes. At this width, values that differ from the code only in the upper byte come within reach. So do values that have only reserved halt-word bits set. Both show that the comparisons look at the whole word rather than at its low byte or low bit. A behavioural model tracks the mode, the slots and the expected strobe on every clock.

// File: rtl/smm_resume_pkg.sv
`timescale 1ns/1ps
package smm_resume_pkg;
  typedef enum logic [3:0] {
    ACT_NONE       = 4'b0000,
    ACT_NEXT       = 4'b0001,
    ACT_AFTER_HALT = 4'b0010,
    ACT_HALT       = 4'b0100,
    ACT_IO_REEXEC  = 4'b1000
  } resume_act_e;

  typedef struct packed {
    logic halted;
    logic io_bnd;
  } entry_cap_t;
endpackage

// File: rtl/smm_save_slots.sv
`timescale 1ns/1ps
module smm_save_slots
  import smm_resume_pkg::*;
#(
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_take,
  input  logic              halted_i,
  input  logic              io_bnd_i,
  input  logic              wr_take,
  input  logic              wr_sel,
  input  logic [SLOT_W-1:0] wr_data,
  output entry_cap_t        cap_o,
  output logic [SLOT_W-1:0] io_slot_o,
  output logic [SLOT_W-1:0] halt_word_o
);
  localparam logic [SLOT_W-1:0] SLOT_ZERO = '0;

  entry_cap_t        cap_q, cap_d;
  logic [SLOT_W-1:0] io_q, io_d, hw_q, hw_d;

  always_comb begin
    cap_d = cap_q;
    io_d  = io_q;
    hw_d  = hw_q;
    if (entry_take) begin
      cap_d.halted = halted_i;
      cap_d.io_bnd = io_bnd_i;
      io_d         = SLOT_ZERO;
      hw_d         = {{(SLOT_W-1){1'b0}}, halted_i};
    end else if (wr_take) begin
      if (wr_sel) hw_d = wr_data;
      else        io_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
      io_q  <= SLOT_ZERO;
      hw_q  <= SLOT_ZERO;
    end else begin
      cap_q <= cap_d;
      io_q  <= io_d;
      hw_q  <= hw_d;
    end
  end

  assign cap_o       = cap_q;
  assign io_slot_o   = io_q;
  assign halt_word_o = hw_q;
endmodule

// File: rtl/smm_resume_decode.sv
`timescale 1ns/1ps
module smm_resume_decode
  import smm_resume_pkg::*;
#(
  parameter int              SLOT_W     = 16,
  parameter logic [SLOT_W-1:0] REEXEC_VAL = 16'h00FF
) (
  input  entry_cap_t        cap_i,
  input  logic              halt_flag_i,
  input  logic [SLOT_W-1:0] io_slot_i,
  output resume_act_e       act_o,
  output logic              err_o
);
  logic io_zero, io_magic, bad_halt, bad_io;

  always_comb begin
    io_zero  = (io_slot_i == '0);
    io_magic = (io_slot_i == REEXEC_VAL);
    bad_halt = !cap_i.halted && halt_flag_i;
    bad_io   = !io_zero && (!cap_i.io_bnd || !io_magic);
    err_o    = bad_halt || bad_io;
    if (err_o)                   act_o = ACT_NEXT;
    else if (io_magic)           act_o = ACT_IO_REEXEC;
    else if (!cap_i.halted)      act_o = ACT_NEXT;
    else if (halt_flag_i)        act_o = ACT_HALT;
    else                         act_o = ACT_AFTER_HALT;
  end
endmodule

// File: rtl/smm_action_reg.sv
`timescale 1ns/1ps
module smm_action_reg
  import smm_resume_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fire_i,
  input  resume_act_e act_i,
  input  logic        err_i,
  output logic        valid_o,
  output logic [3:0]  act_o,
  output logic        err_o
);
  logic       valid_q, valid_d, err_q, err_d;
  logic [3:0] act_q, act_d;

  always_comb begin
    valid_d = fire_i;
    act_d   = fire_i ? act_i : ACT_NONE;
    err_d   = fire_i && err_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      act_q   <= 4'b0000;
      err_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      act_q   <= act_d;
      err_q   <= err_d;
    end
  end

  assign valid_o = valid_q;
  assign act_o   = act_q;
  assign err_o   = err_q;
endmodule

// File: rtl/smm_resume_ctl.sv
`timescale 1ns/1ps
module smm_resume_ctl
  import smm_resume_pkg::*;
#(
  parameter int                SLOT_W     = 16,
  parameter logic [SLOT_W-1:0] REEXEC_VAL = 16'h00FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_i,
  input  logic              halted_i,
  input  logic              io_boundary_i,
  input  logic              rsm_req_i,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [SLOT_W-1:0] reg_wdata_i,
  output logic [SLOT_W-1:0] reg_rdata_o,
  output logic              in_smm_o,
  output logic              act_valid_o,
  output logic [3:0]        act_o,
  output logic              act_err_o
);
  logic              in_smm_q, in_smm_d;
  logic              entry_take, rsm_take, wr_take;
  entry_cap_t        cap;
  logic [SLOT_W-1:0] io_slot_q, halt_word_q;
  resume_act_e       dec_act;
  logic              dec_err;

  always_comb begin
    entry_take = entry_i && !in_smm_q;
    rsm_take   = rsm_req_i && in_smm_q;
    wr_take    = reg_wr_i && in_smm_q && !rsm_req_i;
    in_smm_d   = in_smm_q;
    if (entry_take)    in_smm_d = 1'b1;
    else if (rsm_take) in_smm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_smm_q <= 1'b0;
    else        in_smm_q <= in_smm_d;
  end

  smm_save_slots #(.SLOT_W(SLOT_W)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .entry_take (entry_take),
    .halted_i   (halted_i),
    .io_bnd_i   (io_boundary_i),
    .wr_take    (wr_take),
    .wr_sel     (reg_sel_i),
    .wr_data    (reg_wdata_i),
    .cap_o      (cap),
    .io_slot_o  (io_slot_q),
    .halt_word_o(halt_word_q)
  );

  smm_resume_decode #(.SLOT_W(SLOT_W), .REEXEC_VAL(REEXEC_VAL)) u_dec (
    .cap_i      (cap),
    .halt_flag_i(halt_word_q[0]),
    .io_slot_i  (io_slot_q),
    .act_o      (dec_act),
    .err_o      (dec_err)
  );

  smm_action_reg u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire_i (rsm_take),
    .act_i  (dec_act),
    .err_i  (dec_err),
    .valid_o(act_valid_o),
    .act_o  (act_o),
    .err_o  (act_err_o)
  );

  assign reg_rdata_o = reg_sel_i ? halt_word_q : io_slot_q;
  assign in_smm_o    = in_smm_q;
endmodule

// File: rtl/smm_resume_chk.sv
`timescale 1ns/1ps
module smm_resume_chk #(
  parameter int SLOT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              entry_i,
  input logic              halted_i,
  input logic              rsm_req_i,
  input logic              in_smm_o,
  input logic              act_valid_o,
  input logic [3:0]        act_o,
  input logic              act_err_o,
  input logic [SLOT_W-1:0] io_slot,
  input logic [SLOT_W-1:0] halt_word
);
  p_entry_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_i && !in_smm_o) |=> (in_smm_o && io_slot == '0 &&
      halt_word == {{(SLOT_W-1){1'b0}}, $past(halted_i)}));

  p_wr_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_smm_o && !entry_i) |=> ($stable(io_slot) && $stable(halt_word)));

  p_strobe_after_rsm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsm_req_i && in_smm_o) |=> (act_valid_o && !in_smm_o));

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid_o |=> !act_valid_o);

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid_o |-> $past(rsm_req_i && in_smm_o));

  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid_o |-> ($countones(act_o) == 1));

  p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid_o |-> (act_o == 4'b0000 && !act_err_o));

  p_err_fallback_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid_o && act_err_o) |-> (act_o == 4'b0001));
endmodule

bind smm_resume_ctl smm_resume_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .entry_i    (entry_i),
  .halted_i   (halted_i),
  .rsm_req_i  (rsm_req_i),
  .in_smm_o   (in_smm_o),
  .act_valid_o(act_valid_o),
  .act_o      (act_o),
  .act_err_o  (act_err_o),
  .io_slot    (io_slot_q),
  .halt_word  (halt_word_q)
);

// File: tb/smm_resume_ctl_tb_top.sv
`timescale 1ns/1ps
module smm_resume_ctl_tb_top;
  localparam int W = 16;
  localparam logic [3:0] A_NEXT = 4'b0001, A_AH = 4'b0010, A_HALT = 4'b0100, A_IO = 4'b1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic entry = 0, halted = 0, iob = 0, rsm = 0, wr = 0, sel = 0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic in_smm, vld, err;
  logic [3:0] act;

  int checks = 0, fails = 0;
  string phase = "R1";

  smm_resume_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .entry_i(entry), .halted_i(halted),
    .io_boundary_i(iob), .rsm_req_i(rsm), .reg_wr_i(wr), .reg_sel_i(sel),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .in_smm_o(in_smm),
    .act_valid_o(vld), .act_o(act), .act_err_o(err)
  );

  // behavioural reference model
  bit m_in, m_e, m_b, m_v, m_err;
  logic [3:0] m_act;
  logic [W-1:0] m_hw, m_io;

  task automatic decide(output logic [3:0] a, output bit er);
    er = (!m_e && m_hw[0]) || (m_io != 0 && !m_b) || (m_io != 0 && m_io != 16'h00FF);
    if (er) a = A_NEXT;
    else if (m_io == 16'h00FF) a = A_IO;
    else if (m_e && m_hw[0]) a = A_HALT;
    else if (m_e) a = A_AH;
    else a = A_NEXT;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in = 0; m_e = 0; m_b = 0; m_v = 0; m_err = 0; m_act = 0; m_hw = 0; m_io = 0;
    end else begin
      bit was_in;
      was_in = m_in;
      m_v = 0; m_act = 0; m_err = 0;
      if (was_in && rsm) begin
        decide(m_act, m_err);
        m_v = 1; m_in = 0;
      end else if (was_in && wr) begin
        if (sel) m_hw = wdata; else m_io = wdata;
      end
      if (!was_in && entry) begin
        m_in = 1; m_e = halted; m_b = iob; m_io = 0; m_hw = {15'b0, halted};
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk({phase, " model in_smm"}, in_smm, m_in);
    chk({phase, " model valid"}, vld, m_v);
    chk({phase, " model act"}, act, m_act);
    chk({phase, " model err"}, err, m_err);
    chk({phase, " model rdata"}, rdata, sel ? m_hw : m_io);
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic do_entry(logic h, logic b);
    step(); entry = 1; halted = h; iob = b;
    step(); entry = 0; halted = 0; iob = 0;
  endtask

  task automatic do_wr(logic s, logic [W-1:0] d);
    step(); wr = 1; sel = s; wdata = d;
    step(); wr = 0;
  endtask

  task automatic rd_chk(string tag, logic s, logic [W-1:0] exp);
    step(); sel = s;
    @(negedge clk); chk(tag, rdata, exp);
  endtask

  task automatic resume_chk(string tag, logic [3:0] ea, logic ee);
    step(); rsm = 1;
    step(); rsm = 0;
    @(negedge clk);
    chk({tag, " valid"}, vld, 1'b1);
    chk({tag, " act"}, act, ea);
    chk({tag, " err"}, err, ee);
    chk({tag, " left mode"}, in_smm, 1'b0);
    @(negedge clk);
    chk({tag, " strobe one cycle"}, vld, 1'b0);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    phase = "R1";
    chk("R1 reset in_smm", in_smm, 0);
    chk("R1 reset valid", vld, 0);
    chk("R5 reset act zero", act, 0);

    // R1 entry initialisation, R6 plain return
    do_wr(0, 16'h1234); // outside mode: R3 ignored
    phase = "R3";
    rd_chk("R3 write outside mode ignored", 0, 16'h0000);
    phase = "R1";
    do_entry(0, 0);
    rd_chk("R1 io word cleared", 0, 16'h0000);
    rd_chk("R1 halt word from halted", 1, 16'h0000);
    phase = "R6";
    resume_chk("R6 next instruction", A_NEXT, 0);

    // R8 re-enter halt; R1 halt bit loaded
    phase = "R8";
    do_entry(1, 0);
    rd_chk("R1 halt word bit0 set", 1, 16'h0001);
    resume_chk("R8 re-enter halt", A_HALT, 0);

    // R7 after HALT
    phase = "R7";
    do_entry(1, 0);
    do_wr(1, 16'h0000);
    resume_chk("R7 after halt", A_AH, 0);

    // R2 readback both slots, R9 I/O re-execute
    phase = "R2";
    do_entry(0, 1);
    do_wr(0, 16'h00FF);
    do_wr(1, 16'h0000);
    rd_chk("R2 io word readback", 0, 16'h00FF);
    rd_chk("R2 halt word readback", 1, 16'h0000);
    phase = "R9";
    resume_chk("R9 io reexec", A_IO, 0);

    // R9 priority over halt restart
    do_entry(1, 1);
    do_wr(0, 16'h00FF);
    resume_chk("R9 io over halt", A_IO, 0);

    // R10 error cases
    phase = "R10";
    do_entry(0, 0);
    do_wr(1, 16'h0001);
    resume_chk("R10 halt 0 to 1", A_NEXT, 1);
    do_entry(1, 0);
    do_wr(0, 16'h00FF);
    resume_chk("R10 io without boundary", A_NEXT, 1);
    do_entry(0, 1);
    do_wr(0, 16'h0012);
    resume_chk("R10 io bad code", A_NEXT, 1);
    do_entry(0, 1);
    do_wr(0, 16'h01FF);
    resume_chk("R10 io upper byte differs", A_NEXT, 1);

    // R11 reserved bits ignored, entry status latched
    phase = "R11";
    do_entry(1, 0);
    do_wr(1, 16'hFFFE);
    resume_chk("R11 reserved bits ignored", A_AH, 0);
    do_entry(0, 0);
    do_wr(1, 16'hFFFE);
    resume_chk("R11 reserved bits no error", A_NEXT, 0);

    // R3 entry while in mode ignored
    phase = "R3";
    do_entry(0, 0);
    do_entry(1, 1);
    rd_chk("R3 re-entry ignored halt word", 1, 16'h0000);
    do_wr(0, 16'h00FF);
    resume_chk("R3 re-entry kept boundary clear", A_NEXT, 1);

    // R4 resume outside mode, write with resume dropped
    phase = "R4";
    step(); rsm = 1;
    step(); rsm = 0;
    @(negedge clk);
    chk("R4 no strobe outside mode", vld, 0);
    do_entry(1, 0);
    step(); rsm = 1; wr = 1; sel = 1; wdata = 16'h0000;
    step(); rsm = 0; wr = 0;
    @(negedge clk);
    chk("R4 same-cycle write dropped act", act, A_HALT);
    rd_chk("R4 same-cycle write dropped word", 1, 16'h0001);

    repeat (3) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule